// File: doc/BRIEF.md
# Multiplexed Display and Key Matrix Scanner

This block drives a nine-digit, time-multiplexed seven-segment display. The same digit strobes also serve as the row lines of a nine-row, three-column key matrix. The system clock is divided into states of four clocks each. Eleven states make one digit slot. A scan is made of ten slots: nine real digits, walked from the highest digit down to the lowest, and then one dead slot in which no digit is lit. In the first and last state of every slot, all strobes and segment lines are held low. This gives the display drivers clean edges between digits.

The arithmetic core presents the segment pattern for the digit named by `digit_idx`, and the block passes that pattern to the segment pins inside the visible window. The column lines are sampled once per real digit, at the first clock of state S6. The first key seen in a scan is kept as that scan's hit. At the end of each scan the block decides whether to report it. A key is reported only after two consecutive scans see the same key. The report is a one-cycle pulse together with the key's row and column code. After that, nothing more is reported until a scan passes with no key seen at all.

Top module: `mux_scanner`

## Requirements
- R1: One state lasts 4 clocks and one digit slot lasts 11 states (S1..S11, 44 clocks). A full scan is 10 slots, or 440 clocks, and then it repeats.
- R2: The real digits are strobed in the order 9, 8, ... 1, and the dead slot follows. Strobe bit k belongs to digit k+1. `digit_idx` shows the current slot's digit number (9..1) for the whole slot, and 0 in the dead slot.
- R3: During S1 and S11 of every slot, `digit_strobe` and `seg_out` are all zero. In S2..S10 of a real digit, `seg_out` equals `seg_in`, with bit 0 as segment A through bit 6 as segment G and bit 7 as the decimal point.
- R4: In the dead slot, no strobe is asserted and `seg_out` is zero.
- R5: At most one digit strobe is high in any cycle.
- R6: Reset is synchronous and active high. It puts the block at digit 9, state S1, first clock. In that state all strobes and segments are low, `key_valid` is 0 and `key_row`/`key_col` are 0. The first strobe (bit 8) rises 4 clocks after reset is released.
- R7: Column lines are active high and are sampled at the first clock of S6 of each real digit. A hit is coded with the row equal to the digit number (1..9) and the column equal to the input index (0..2). Only the first hit in a scan counts: the higher digit wins, and within one row the lowest column index wins.
- R8: When the same hit is seen in two consecutive scans, `key_valid` is high for exactly one clock. That clock is the first clock of the following scan. `key_row`/`key_col` then hold that code until the next report.
- R9: A key that stays pressed is not reported again. Reporting is re-armed only after one full scan with no hit.
- R10: Column activity that never coincides with the S6 sampling point has no effect: no report is made and the held code does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_in | input | 8 | Segment pattern for the current digit (A..G, DP) |
| col_in | input | 3 | Key matrix column lines, active high |
| digit_strobe | output | 9 | One-hot digit and row strobes, bit k = digit k+1 |
| seg_out | output | 8 | Blanked segment lines |
| digit_idx | output | 4 | Digit number of the current slot, 0 in the dead slot |
| key_valid | output | 1 | One-clock key report pulse |
| key_row | output | 4 | Row (digit number) of the last reported key |
| key_col | output | 2 | Column index of the last reported key |

## Verification
The hardest state to reach from the ports is a column that is active in every state except the single sampling clock of S6. To produce it, the bench keeps its own count of clocks since reset and derives the current state from that count. It then drives the columns as a glitch that skips the sampling point. The report path needs a key that stays stable across two whole scans and then across two more. The bench's keyboard model does this by answering the live strobes, and every press is aligned to a scan boundary so that the report clock is known exactly. Two simultaneous keys check the rule that the first hit in a scan wins.

// File: rtl/scan_pkg.sv
package scan_pkg;
    // Key report sequencing across scans
    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,  // armed, no candidate
        KS_SEEN = 2'd1,  // armed, candidate from last scan
        KS_HELD = 2'd2   // reported, waiting for an empty scan
    } kscan_e;
endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
    parameter int CLKS_PER_STATE   = 4,
    parameter int STATES_PER_DIGIT = 11,
    parameter int NUM_SLOTS        = 10,
    localparam int CW = (CLKS_PER_STATE > 1) ? $clog2(CLKS_PER_STATE) : 1,
    localparam int SW = $clog2(STATES_PER_DIGIT),
    localparam int DW = $clog2(NUM_SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt,
    output logic [SW-1:0] st,
    output logic [DW-1:0] slot,
    output logic          scan_end
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [SW-1:0] st;
        logic [DW-1:0] slot;
    } tmr_t;

    tmr_t r_d, r_q;
    logic state_end, digit_end;

    always_comb begin
        r_d       = r_q;
        state_end = (r_q.cnt == CW'(CLKS_PER_STATE - 1));
        digit_end = state_end && (r_q.st == SW'(STATES_PER_DIGIT - 1));
        scan_end  = digit_end && (r_q.slot == DW'(NUM_SLOTS - 1));
        if (!state_end) begin
            r_d.cnt = r_q.cnt + CW'(1);
        end else begin
            r_d.cnt = '0;
            if (!digit_end) begin
                r_d.st = r_q.st + SW'(1);
            end else begin
                r_d.st   = '0;
                r_d.slot = scan_end ? '0 : r_q.slot + DW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign cnt  = r_q.cnt;
    assign st   = r_q.st;
    assign slot = r_q.slot;

    // R1
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cnt) != CW'(CLKS_PER_STATE - 1)) |-> $stable(st));
    // R1
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(st) != SW'(STATES_PER_DIGIT - 1)) |-> $stable(slot));
endmodule

// File: rtl/key_sampler.sv
module key_sampler
    import scan_pkg::*;
#(
    parameter int ROW_W    = 4,
    parameter int NUM_COLS = 3,
    localparam int CLW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample,
    input  logic [ROW_W-1:0] row,
    input  logic [NUM_COLS-1:0] cols,
    input  logic             scan_end,
    output logic             key_valid,
    output logic [ROW_W-1:0] key_row,
    output logic [CLW-1:0]   key_col
);
    typedef struct packed {
        kscan_e           phase;
        logic             hit;
        logic [ROW_W-1:0] hit_row;
        logic [CLW-1:0]   hit_col;
        logic [ROW_W-1:0] prev_row;
        logic [CLW-1:0]   prev_col;
        logic             valid;
        logic [ROW_W-1:0] out_row;
        logic [CLW-1:0]   out_col;
    } ks_t;

    ks_t k_d, k_q;
    logic [CLW-1:0] enc;
    logic           any;

    // lowest column index wins
    always_comb begin
        enc = '0;
        any = 1'b0;
        for (int i = NUM_COLS - 1; i >= 0; i--) begin
            if (cols[i]) begin
                enc = CLW'(i);
                any = 1'b1;
            end
        end
    end

    always_comb begin
        k_d       = k_q;
        k_d.valid = 1'b0;
        if (sample && any && !k_q.hit) begin
            k_d.hit     = 1'b1;
            k_d.hit_row = row;
            k_d.hit_col = enc;
        end
        if (scan_end) begin
            k_d.hit = 1'b0;
            if (!k_q.hit) begin
                k_d.phase = KS_IDLE;
            end else begin
                case (k_q.phase)
                    KS_IDLE: begin
                        k_d.phase    = KS_SEEN;
                        k_d.prev_row = k_q.hit_row;
                        k_d.prev_col = k_q.hit_col;
                    end
                    KS_SEEN: begin
                        if (k_q.prev_row == k_q.hit_row && k_q.prev_col == k_q.hit_col) begin
                            k_d.phase   = KS_HELD;
                            k_d.valid   = 1'b1;
                            k_d.out_row = k_q.hit_row;
                            k_d.out_col = k_q.hit_col;
                        end else begin
                            k_d.prev_row = k_q.hit_row;
                            k_d.prev_col = k_q.hit_col;
                        end
                    end
                    default: k_d.phase = KS_HELD;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) k_q <= '0;
        else     k_q <= k_d;
    end

    assign key_valid = k_q.valid;
    assign key_row   = k_q.out_row;
    assign key_col   = k_q.out_col;

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        key_valid |=> !key_valid);
    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !key_valid) |-> ($stable(key_row) && $stable(key_col)));
    // R8
    report_at_scan_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(key_valid) |-> $past(scan_end));
endmodule

// File: rtl/mux_scanner.sv
module mux_scanner #(
    parameter int NUM_DIGITS       = 9,
    parameter int NUM_COLS         = 3,
    parameter int SEG_W            = 8,
    parameter int CLKS_PER_STATE   = 4,
    parameter int STATES_PER_DIGIT = 11,
    parameter int SAMPLE_STATE     = 5,
    localparam int NUM_SLOTS = NUM_DIGITS + 1,
    localparam int IW  = $clog2(NUM_DIGITS + 1),
    localparam int CLW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SEG_W-1:0]      seg_in,
    input  logic [NUM_COLS-1:0]   col_in,
    output logic [NUM_DIGITS-1:0] digit_strobe,
    output logic [SEG_W-1:0]      seg_out,
    output logic [IW-1:0]         digit_idx,
    output logic                  key_valid,
    output logic [IW-1:0]         key_row,
    output logic [CLW-1:0]        key_col
);
    localparam int CW = (CLKS_PER_STATE > 1) ? $clog2(CLKS_PER_STATE) : 1;
    localparam int SW = $clog2(STATES_PER_DIGIT);
    localparam int DW = $clog2(NUM_SLOTS);

    logic [CW-1:0] cnt_w;
    logic [SW-1:0] st_w;
    logic [DW-1:0] slot_w;
    logic          scan_end_w;
    logic          dead, blank, sample;

    scan_timer #(
        .CLKS_PER_STATE  (CLKS_PER_STATE),
        .STATES_PER_DIGIT(STATES_PER_DIGIT),
        .NUM_SLOTS       (NUM_SLOTS)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt_w),
        .st      (st_w),
        .slot    (slot_w),
        .scan_end(scan_end_w)
    );

    always_comb begin
        dead      = (slot_w == DW'(NUM_DIGITS));
        blank     = dead || (st_w == '0) || (st_w == SW'(STATES_PER_DIGIT - 1));
        sample    = !dead && (st_w == SW'(SAMPLE_STATE)) && (cnt_w == '0);
        digit_idx = dead ? '0 : IW'(NUM_DIGITS) - IW'(slot_w);
        seg_out   = blank ? '0 : seg_in;
    end

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_strobe
        assign digit_strobe[g] = !blank && (slot_w == DW'(NUM_DIGITS - 1 - g));
    end

    key_sampler #(
        .ROW_W   (IW),
        .NUM_COLS(NUM_COLS)
    ) u_keys (
        .clk      (clk),
        .rst      (rst),
        .sample   (sample),
        .row      (digit_idx),
        .cols     (col_in),
        .scan_end (scan_end_w),
        .key_valid(key_valid),
        .key_row  (key_row),
        .key_col  (key_col)
    );

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(digit_strobe));
    // R3
    strobe_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(|digit_strobe)) |->
            ($past(st_w) == '0 && $past(cnt_w) == CW'(CLKS_PER_STATE - 1)));
    // R3
    strobe_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(|digit_strobe)) |->
            (st_w == SW'(STATES_PER_DIGIT - 1) && cnt_w == '0));
    // R2
    digit_order_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && digit_idx != $past(digit_idx)) |->
            (digit_idx == $past(digit_idx) - IW'(1) ||
             ($past(digit_idx) == '0 && digit_idx == IW'(NUM_DIGITS))));
    // R4
    dead_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (digit_idx == '0) |-> (digit_strobe == '0 && seg_out == '0));
endmodule

// File: tb/mux_scanner_tb.sv
module mux_scanner_tb;
    localparam int SCAN = 440;
    // {row[3:0], col[1:0]} presses walked by the main loop
    localparam logic [5:0] KEYS [0:5] = '{6'h24, 6'h06, 6'h15, 6'h15, 6'h22, 6'h08};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] seg_in = 8'h00;
    logic [2:0] col_in;
    logic [8:0] digit_strobe;
    logic [7:0] seg_out;
    logic [3:0] digit_idx;
    logic       key_valid;
    logic [3:0] key_row;
    logic [1:0] key_col;

    int total = 0;
    int bad   = 0;
    int pcount = 0;
    int pulses = 0;
    bit done = 1'b0;

    logic       k1_en = 1'b0, k2_en = 1'b0, ghost_en = 1'b0;
    logic [3:0] k1_row = 4'd1, k2_row = 4'd1;
    logic [1:0] k1_col = 2'd0, k2_col = 2'd0;
    logic [2:0] ghost = 3'b000;

    always #10 clk = ~clk;

    mux_scanner u_dut (
        .clk(clk), .rst(rst), .seg_in(seg_in), .col_in(col_in),
        .digit_strobe(digit_strobe), .seg_out(seg_out), .digit_idx(digit_idx),
        .key_valid(key_valid), .key_row(key_row), .key_col(key_col)
    );

    // keyboard model answering the live row strobes
    always_comb begin
        col_in = ghost;
        if (k1_en && digit_strobe[k1_row - 4'd1]) col_in[k1_col] = 1'b1;
        if (k2_en && digit_strobe[k2_row - 4'd1]) col_in[k2_col] = 1'b1;
    end

    always @(posedge clk) begin
        if (rst) pcount <= 0;
        else     pcount <= pcount + 1;
        if (key_valid) pulses <= pulses + 1;
    end

    // glitch that is present in every state except S6
    always @(negedge clk) begin
        ghost = (ghost_en && ((pcount / 4) % 11) != 5) ? 3'b111 : 3'b000;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, pcount);
        end
    endtask

    task automatic wait_to(input int target);
        while (pcount != target) @(negedge clk);
    endtask

    task automatic run_press(input logic [3:0] r1, input logic [1:0] c1, input bit two,
                             input logic [3:0] r2, input logic [1:0] c2,
                             input logic [3:0] er, input logic [1:0] ec, input string req);
        int s, p0;
        s = ((pcount / SCAN) + 1) * SCAN;
        wait_to(s);
        k1_row = r1; k1_col = c1; k1_en = 1'b1;
        k2_row = r2; k2_col = c2; k2_en = two;
        p0 = pulses;
        wait_to(s + 2 * SCAN - 1);
        chk(key_valid == 1'b0, "R8 early", int'(key_valid), 0);
        wait_to(s + 2 * SCAN);
        chk(key_valid == 1'b1, "R8 pulse", int'(key_valid), 1);
        chk(key_row == er, {req, " row"}, int'(key_row), int'(er));
        chk(key_col == ec, {req, " col"}, int'(key_col), int'(ec));
        wait_to(s + 2 * SCAN + 1);
        chk(key_valid == 1'b0, "R8 width", int'(key_valid), 0);
        wait_to(s + 4 * SCAN + 1);
        chk(pulses - p0 == 1, "R9 no repeat", pulses - p0, 1);
        chk(key_row == er && key_col == ec, "R8 hold", int'({key_row, key_col}), int'({er, ec}));
        k1_en = 1'b0; k2_en = 1'b0;
        wait_to(s + 5 * SCAN + 2);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        seg_in = 8'hFF;
        #1;
        // R6 reset state
        chk(digit_strobe == 9'h000, "R6 strobe", int'(digit_strobe), 0);
        chk(seg_out == 8'h00, "R6 seg", int'(seg_out), 0);
        chk(digit_idx == 4'd9, "R6 idx", int'(digit_idx), 9);
        chk(key_valid == 1'b0 && key_row == 4'd0 && key_col == 2'd0, "R6 key",
            int'({key_valid, key_row, key_col}), 0);
        rst = 1'b0;

        // R1 R2 R3 R4 R5: cycle-by-cycle sweep of two full scans
        for (int i = 0; i < 2 * SCAN; i++) begin
            int slot, st, exp_idx;
            logic [8:0] exp_str;
            logic [7:0] exp_seg;
            bit blank;
            if (i > 0) @(negedge clk);
            seg_in = 8'(i * 29 + 3);
            #1;
            slot = (pcount / 44) % 10;
            st   = (pcount / 4) % 11;
            blank = (slot == 9) || (st == 0) || (st == 10);
            exp_str = blank ? 9'h000 : (9'h001 << (8 - slot));
            exp_seg = blank ? 8'h00 : seg_in;
            exp_idx = (slot == 9) ? 0 : 9 - slot;
            chk(digit_strobe == exp_str, "R2/R3/R4/R5 strobe", int'(digit_strobe), int'(exp_str));
            chk(seg_out == exp_seg, "R3/R4 seg", int'(seg_out), int'(exp_seg));
            chk(digit_idx == 4'(exp_idx), "R1/R2 idx", int'(digit_idx), exp_idx);
        end

        // R7 R8 R9: table of single presses (repeated entry re-arms after release)
        for (int k = 0; k < 6; k++) begin
            run_press(KEYS[k][5:2], KEYS[k][1:0], 1'b0, 4'd1, 2'd0,
                      KEYS[k][5:2], KEYS[k][1:0], "R7 table");
        end

        // R7: two keys in one scan, higher digit wins
        run_press(4'd3, 2'd0, 1'b1, 4'd9, 2'd2, 4'd9, 2'd2, "R7 row priority");
        // R7: two columns on one row, lowest index wins
        run_press(4'd4, 2'd2, 1'b1, 4'd4, 2'd1, 4'd4, 2'd1, "R7 col priority");

        // R10: columns active only outside the sampling clock
        begin
            int s, p0;
            s = ((pcount / SCAN) + 1) * SCAN;
            wait_to(s);
            p0 = pulses;
            ghost_en = 1'b1;
            wait_to(s + 4 * SCAN + 2);
            ghost_en = 1'b0;
            chk(pulses == p0, "R10 pulses", pulses - p0, 0);
            chk(key_row == 4'd4 && key_col == 2'd1, "R10 held code",
                int'({key_row, key_col}), int'({4'd4, 2'd1}));
        end

        // R6: reset in mid-scan
        wait_to(pcount + 123);
        rst = 1'b1;
        seg_in = 8'h5A;
        repeat (2) @(negedge clk);
        #1;
        chk(digit_strobe == 9'h000 && seg_out == 8'h00, "R6 mid strobe/seg",
            int'({digit_strobe, seg_out}), 0);
        chk(digit_idx == 4'd9, "R6 mid idx", int'(digit_idx), 9);
        chk(key_row == 4'd0 && key_col == 2'd0 && !key_valid, "R6 mid key",
            int'({key_valid, key_row, key_col}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(digit_strobe == 9'h000, "R6 still S1", int'(digit_strobe), 0);
        @(negedge clk);
        #1;
        chk(digit_strobe == 9'h100, "R6 first strobe", int'(digit_strobe), 256);
        chk(seg_out == 8'h5A, "R3 pass", int'(seg_out), 90);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule